// File: doc/BRIEF.md
# DMA Address-Count Engine with Buffer Chaining

This block keeps the moving state of a single DMA channel: a source address, a destination address and a remaining byte count. Each read beat into the channel's data buffer lowers the count and, when allowed, advances the source address. Each write beat out of the buffer advances the destination address. The block chooses the width of every read beat. That width is the configured width, reduced when fewer bytes remain. Transfer lengths that are not multiples of the word size therefore finish with smaller beats and never overshoot.

Buffer chaining uses three shadow registers: a source reload, a destination reload and a count reload, plus a one-shot arm bit. When the count reaches zero with the arm bit set, all three live values are replaced by their shadows in the same cycle. The arm bit then clears and the channel keeps running. When the count reaches zero without the arm bit, the channel stops. Software may rewrite the shadows and the arm bit while a transfer is in progress. The live registers are locked during that time.

A two-state controller sequences the channel. `ST_IDLE` accepts live register writes and waits for a start request. `ST_RUN` consumes read beats. The transitions are named as follows. START moves from `ST_IDLE` to `ST_RUN` on a start request with a nonzero count. CHAIN is the `ST_RUN` self-loop taken when the count hits zero while armed. FINISH moves from `ST_RUN` back to `ST_IDLE` when the count hits zero unarmed.

Top module: `chan_xfer_tracker`

## Requirements
- R1: After reset both addresses and the count are 0, the channel is inactive, the arm bit is 0, and both event pulses are low.
- R2: `chan_go` with a nonzero count makes `chan_active` 1 on the next cycle. `chan_go` with a zero count leaves the channel idle. Writes with `reg_sel` 0 (source), 1 (destination) or 2 (count, bits 23:0) take effect only while idle and are ignored while active.
- R3: `rd_width` is the largest of byte (code 0, 1 byte), halfword (code 1, 2 bytes) and word (code 2, 4 bytes) that does not exceed either the configured source width or the remaining count. Configured code 3 acts as word. A remaining count of 0 gives byte.
- R4: Each `rd_beat` while active lowers the count by the byte size of `rd_width`. A `rd_beat` while idle changes nothing.
- R5: On each active read beat, the source address advances by the beat size when `cfg_src_inc` is 1 and `cfg_req_class` is not 1 (peripheral receive). Otherwise it holds.
- R6: On each `wr_beat`, the destination address advances by the byte size of `wr_width` when `cfg_dst_inc` is 1 and `cfg_req_class` is not 2 (peripheral transmit). Otherwise it holds.
- R7: When a read beat brings the count to zero with the arm bit clear, `chan_active` falls and `ctz_pulse` is 1 for exactly that one following cycle. The source address still shows the last advance.
- R8: When a read beat brings the count to zero with the arm bit set, the source, destination and count load their shadow values (addresses zero-extended from 31 bits). The arm bit clears, `ctz_pulse` and `rld_pulse` are 1 together for one cycle, and the channel stays active.
- R9: Shadow writes are accepted in any state. `reg_sel` 3 and 4 store `reg_wdata[30:0]` as the source and destination shadows. `reg_sel` 5 stores `reg_wdata[23:0]` as the count shadow and `reg_wdata[31]` as the arm bit.
- R10: `burst_len` equals `cfg_burst` plus one, giving 1 to 32 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_src_width | input | 2 | Configured source beat width code |
| cfg_src_inc | input | 1 | Source address increment request |
| cfg_dst_inc | input | 1 | Destination address increment request |
| cfg_req_class | input | 2 | 0/3 memory, 1 peripheral receive, 2 peripheral transmit |
| cfg_burst | input | 5 | Burst field; length is value plus one |
| chan_go | input | 1 | Start request |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select, codes 0..5 |
| reg_wdata | input | 32 | Register write data |
| rd_beat | input | 1 | Read beat into the buffer, of width `rd_width` |
| wr_beat | input | 1 | Write beat out of the buffer |
| wr_width | input | 2 | Width code of the current write beat |
| src_addr | output | 32 | Live source address |
| dst_addr | output | 32 | Live destination address |
| byte_count | output | 24 | Remaining byte count |
| rd_width | output | 2 | Effective read beat width code |
| burst_len | output | 6 | Burst length in bytes |
| ctz_pulse | output | 1 | Count reached zero, one cycle |
| rld_pulse | output | 1 | Shadow reload happened, one cycle |
| chan_active | output | 1 | Channel running |
| rld_armed | output | 1 | One-shot reload arm bit |

## Verification
The hardest state to reach is a chained reload in which the shadows were rewritten while the channel was running. The old buffer must end on a narrowed final beat, and the new buffer must then run to a second, unarmed stop. The stimulus starts a one-byte buffer, arms the shadows mid-run through the normal write path, and fires one read beat. It then checks the swapped addresses, the cleared arm bit and the paired pulses. A final read beat on the two-byte reloaded count checks the halfword narrowing and the stop.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } chan_state_e;

    localparam logic [2:0] SEL_SRC     = 3'd0;
    localparam logic [2:0] SEL_DST     = 3'd1;
    localparam logic [2:0] SEL_CNT     = 3'd2;
    localparam logic [2:0] SEL_SRC_RLD = 3'd3;
    localparam logic [2:0] SEL_DST_RLD = 3'd4;
    localparam logic [2:0] SEL_CNT_RLD = 3'd5;

    localparam logic [1:0] CLASS_PRX = 2'd1;
    localparam logic [1:0] CLASS_PTX = 2'd2;

    function automatic logic [2:0] width_bytes(input logic [1:0] code);
        unique case (code)
            2'd0:    width_bytes = 3'd1;
            2'd1:    width_bytes = 3'd2;
            default: width_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/xfer_beat_sizer.sv
module xfer_beat_sizer #(
    parameter int CNT_W = 24
) (
    input  logic [1:0]       cfg_width,
    input  logic [CNT_W-1:0] remain,
    output logic [1:0]       eff_width
);
    always_comb begin
        if (cfg_width >= 2'd2 && remain >= CNT_W'(4))
            eff_width = 2'd2;
        else if (cfg_width >= 2'd1 && remain >= CNT_W'(2))
            eff_width = 2'd1;
        else
            eff_width = 2'd0;
    end
endmodule

// File: rtl/xfer_addr_stepper.sv
module xfer_addr_stepper #(
    parameter int ADDR_W = 32,
    parameter int RLD_W  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              live_wr,
    input  logic [ADDR_W-1:0] live_data,
    input  logic              shadow_wr,
    input  logic [RLD_W-1:0]  shadow_data,
    input  logic              reload,
    input  logic              step,
    input  logic [2:0]        step_bytes,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;
    logic [RLD_W-1:0]  shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (shadow_wr) begin
            shadow_q <= shadow_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (reload) begin
            addr_q <= ADDR_W'(shadow_q);
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(step_bytes);
        end else if (live_wr) begin
            addr_q <= live_data;
        end
    end

    assign addr = addr_q;

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && !step && !live_wr) |=> $stable(addr));

endmodule

// File: rtl/xfer_count_ctrl.sv
module xfer_count_ctrl
    import xfer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_data,
    input  logic             crld_wr,
    input  logic [CNT_W-1:0] crld_data,
    input  logic             crld_arm,
    input  logic             rd_beat,
    input  logic [2:0]       beat_bytes,
    output logic [CNT_W-1:0] count,
    output logic             active,
    output logic             armed,
    output logic             ctz_pulse,
    output logic             rld_pulse,
    output logic             reload_now,
    output logic             beat_ok
);
    chan_state_e      state_q, state_d;
    logic [CNT_W-1:0] count_q, shadow_cnt_q;
    logic             armed_q, ctz_q, rld_q;
    logic             hits_zero;

    assign beat_ok    = (state_q == ST_RUN) && rd_beat;
    assign hits_zero  = beat_ok && (count_q <= CNT_W'(beat_bytes));
    assign reload_now = hits_zero && armed_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go && count_q != '0)        state_d = ST_RUN;   // START
            ST_RUN:  if (hits_zero && !armed_q)      state_d = ST_IDLE;  // FINISH
            default:                                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q      <= '0;
            shadow_cnt_q <= '0;
            armed_q      <= 1'b0;
            ctz_q        <= 1'b0;
            rld_q        <= 1'b0;
        end else begin
            ctz_q <= hits_zero;
            rld_q <= reload_now;
            if (reload_now)                        // CHAIN
                count_q <= shadow_cnt_q;
            else if (beat_ok)
                count_q <= count_q - CNT_W'(beat_bytes);
            else if (cnt_wr && state_q == ST_IDLE)
                count_q <= cnt_data;
            if (crld_wr) begin
                shadow_cnt_q <= crld_data;
                armed_q      <= crld_arm;
            end else if (reload_now) begin
                armed_q      <= 1'b0;
            end
        end
    end

    assign count     = count_q;
    assign active    = (state_q == ST_RUN);
    assign armed     = armed_q;
    assign ctz_pulse = ctz_q;
    assign rld_pulse = rld_q;

    assert_stop_flags_ctz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ctz_pulse);

    assert_chain_keeps_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rld_pulse |-> (active && ctz_pulse));

    assert_arm_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_pulse && !$past(crld_wr)) |-> !armed);

    assert_count_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt_wr && !rd_beat) |=> $stable(count));

endmodule

// File: rtl/chan_xfer_tracker.sv
module chan_xfer_tracker
    import xfer_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int RLD_W   = 31,
    parameter int CNT_W   = 24,
    parameter int BURST_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_src_width,
    input  logic               cfg_src_inc,
    input  logic               cfg_dst_inc,
    input  logic [1:0]         cfg_req_class,
    input  logic [BURST_W-1:0] cfg_burst,
    input  logic               chan_go,
    input  logic               reg_wr,
    input  logic [2:0]         reg_sel,
    input  logic [ADDR_W-1:0]  reg_wdata,
    input  logic               rd_beat,
    input  logic               wr_beat,
    input  logic [1:0]         wr_width,
    output logic [ADDR_W-1:0]  src_addr,
    output logic [ADDR_W-1:0]  dst_addr,
    output logic [CNT_W-1:0]   byte_count,
    output logic [1:0]         rd_width,
    output logic [BURST_W:0]   burst_len,
    output logic               ctz_pulse,
    output logic               rld_pulse,
    output logic               chan_active,
    output logic               rld_armed
);
    localparam int NUM_PTR = 2;

    logic              reload_now, beat_ok;
    logic              src_inc_eff, dst_inc_eff;
    logic [NUM_PTR-1:0] live_wr, shadow_wr, step;
    logic [2:0]        step_bytes [NUM_PTR];
    logic [ADDR_W-1:0] ptr        [NUM_PTR];

    assign src_inc_eff = cfg_src_inc && (cfg_req_class != CLASS_PRX);
    assign dst_inc_eff = cfg_dst_inc && (cfg_req_class != CLASS_PTX);

    xfer_beat_sizer #(.CNT_W(CNT_W)) u_sizer (
        .cfg_width (cfg_src_width),
        .remain    (byte_count),
        .eff_width (rd_width)
    );

    xfer_count_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (chan_go),
        .cnt_wr     (reg_wr && reg_sel == SEL_CNT),
        .cnt_data   (reg_wdata[CNT_W-1:0]),
        .crld_wr    (reg_wr && reg_sel == SEL_CNT_RLD),
        .crld_data  (reg_wdata[CNT_W-1:0]),
        .crld_arm   (reg_wdata[ADDR_W-1]),
        .rd_beat    (rd_beat),
        .beat_bytes (width_bytes(rd_width)),
        .count      (byte_count),
        .active     (chan_active),
        .armed      (rld_armed),
        .ctz_pulse  (ctz_pulse),
        .rld_pulse  (rld_pulse),
        .reload_now (reload_now),
        .beat_ok    (beat_ok)
    );

    always_comb begin
        live_wr[0]    = reg_wr && reg_sel == SEL_SRC && !chan_active;
        live_wr[1]    = reg_wr && reg_sel == SEL_DST && !chan_active;
        shadow_wr[0]  = reg_wr && reg_sel == SEL_SRC_RLD;
        shadow_wr[1]  = reg_wr && reg_sel == SEL_DST_RLD;
        step[0]       = beat_ok && src_inc_eff;
        step[1]       = wr_beat && dst_inc_eff;
        step_bytes[0] = width_bytes(rd_width);
        step_bytes[1] = width_bytes(wr_width);
    end

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        xfer_addr_stepper #(.ADDR_W(ADDR_W), .RLD_W(RLD_W)) u_step (
            .clk         (clk),
            .rst_n       (rst_n),
            .live_wr     (live_wr[i]),
            .live_data   (reg_wdata),
            .shadow_wr   (shadow_wr[i]),
            .shadow_data (reg_wdata[RLD_W-1:0]),
            .reload      (reload_now),
            .step        (step[i]),
            .step_bytes  (step_bytes[i]),
            .addr        (ptr[i])
        );
    end

    assign src_addr  = ptr[0];
    assign dst_addr  = ptr[1];
    assign burst_len = {1'b0, cfg_burst} + 1'b1;

    assert_width_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chan_active |-> (CNT_W'(width_bytes(rd_width)) <= byte_count));

    assert_idle_no_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_active && rd_beat && !reg_wr) |=> $stable(byte_count));

endmodule

// File: tb/tb_chan_xfer_tracker.sv
module tb_chan_xfer_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_src_width = 2'd2;
    logic        cfg_src_inc = 1'b1, cfg_dst_inc = 1'b1;
    logic [1:0]  cfg_req_class = 2'd0;
    logic [4:0]  cfg_burst = 5'd0;
    logic        chan_go = 1'b0, reg_wr = 1'b0, rd_beat = 1'b0, wr_beat = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [1:0]  wr_width = 2'd0;
    logic [31:0] src_addr, dst_addr;
    logic [23:0] byte_count;
    logic [1:0]  rd_width;
    logic [5:0]  burst_len;
    logic        ctz_pulse, rld_pulse, chan_active, rld_armed;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    chan_xfer_tracker dut (
        .clk(clk), .rst_n(rst_n), .cfg_src_width(cfg_src_width),
        .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
        .cfg_req_class(cfg_req_class), .cfg_burst(cfg_burst),
        .chan_go(chan_go), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_beat(rd_beat), .wr_beat(wr_beat),
        .wr_width(wr_width), .src_addr(src_addr), .dst_addr(dst_addr),
        .byte_count(byte_count), .rd_width(rd_width), .burst_len(burst_len),
        .ctz_pulse(ctz_pulse), .rld_pulse(rld_pulse),
        .chan_active(chan_active), .rld_armed(rld_armed)
    );

    typedef struct packed {
        logic [1:0]  cfg;
        logic [23:0] cnt;
        logic [1:0]  exp;
    } wvec_t;

    // R3 width table: configured width, remaining count, expected width code
    localparam wvec_t WTAB [9] = '{
        '{2'd0, 24'd5,   2'd0},
        '{2'd1, 24'd1,   2'd0},
        '{2'd1, 24'd2,   2'd1},
        '{2'd2, 24'd3,   2'd1},
        '{2'd2, 24'd4,   2'd2},
        '{2'd3, 24'd100, 2'd2},
        '{2'd2, 24'd1,   2'd0},
        '{2'd1, 24'd9,   2'd1},
        '{2'd2, 24'd0,   2'd0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wreg(input logic [2:0] sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic go();
        chan_go = 1'b1; tick(); chan_go = 1'b0;
    endtask

    task automatic rd();
        rd_beat = 1'b1; tick(); rd_beat = 1'b0;
    endtask

    task automatic wrb(input logic [1:0] w);
        wr_beat = 1'b1; wr_width = w; tick(); wr_beat = 1'b0;
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk("R1", "src", src_addr, 0);
        chk("R1", "dst", dst_addr, 0);
        chk("R1", "count", byte_count, 0);
        chk("R1", "active", chan_active, 0);
        chk("R1", "armed", rld_armed, 0);
        chk("R1", "pulses", {ctz_pulse, rld_pulse}, 0);
        rst_n = 1'b1;
        tick();

        // R3 table walk (idle, count written directly)
        foreach (WTAB[i]) begin
            wreg(3'd2, {8'd0, WTAB[i].cnt});
            cfg_src_width = WTAB[i].cfg;
            #1;
            chk("R3", $sformatf("width row %0d", i), rd_width, WTAB[i].exp);
        end

        // R10 burst length
        cfg_burst = 5'd31; #1; chk("R10", "burst max", burst_len, 32);
        cfg_burst = 5'd4;  #1; chk("R10", "burst 5",   burst_len, 5);

        // Scenario: 7 bytes word config, increments on
        cfg_src_width = 2'd2;
        wreg(3'd0, 32'h1000);
        wreg(3'd1, 32'h2000);
        wreg(3'd2, 32'd7);
        go();
        chk("R2", "active after start", chan_active, 1);
        rd();
        chk("R4", "count after word", byte_count, 3);
        chk("R5", "src after word", src_addr, 32'h1004);
        chk("R3", "narrowed to half", rd_width, 1);
        rd();
        chk("R4", "count after half", byte_count, 1);
        chk("R5", "src after half", src_addr, 32'h1006);
        rd();
        chk("R7", "count zero", byte_count, 0);
        chk("R7", "src last advance", src_addr, 32'h1007);
        chk("R7", "inactive", chan_active, 0);
        chk("R7", "ctz/rld pulse", {ctz_pulse, rld_pulse}, 2'b10);
        tick();
        chk("R7", "ctz one cycle", ctz_pulse, 0);
        wrb(2'd2);
        chk("R6", "dst word step", dst_addr, 32'h2004);
        wrb(2'd0);
        chk("R6", "dst byte step", dst_addr, 32'h2005);

        // R2 start with zero count ignored
        go();
        chk("R2", "zero-count start", chan_active, 0);
        // R2 live writes locked while active
        wreg(3'd2, 32'd8);
        go();
        wreg(3'd0, 32'hDEAD);
        chk("R2", "src locked", src_addr, 32'h1007);
        wreg(3'd2, 32'd100);
        chk("R2", "count locked", byte_count, 8);
        rd(); rd();
        chk("R7", "second stop", chan_active, 0);
        chk("R5", "src after 8", src_addr, 32'h100F);

        // R4 idle read beat ignored
        wreg(3'd2, 32'd5);
        rd();
        chk("R4", "idle beat count", byte_count, 5);
        chk("R4", "idle beat src", src_addr, 32'h100F);

        // R5 peripheral receive: source holds
        cfg_req_class = 2'd1;
        go();
        rd();
        chk("R5", "prx src hold", src_addr, 32'h100F);
        chk("R4", "prx count", byte_count, 1);
        rd();
        chk("R7", "prx stop", chan_active, 0);
        // R6 peripheral transmit: destination holds
        cfg_req_class = 2'd2;
        wrb(2'd2);
        chk("R6", "ptx dst hold", dst_addr, 32'h2005);
        cfg_dst_inc = 1'b0; cfg_req_class = 2'd0;
        wrb(2'd1);
        chk("R6", "inc off dst hold", dst_addr, 32'h2005);
        cfg_dst_inc = 1'b1;

        // R8/R9 chained reload, shadows written while active
        wreg(3'd0, 32'h100);
        wreg(3'd1, 32'h200);
        wreg(3'd2, 32'd1);
        go();
        wreg(3'd3, 32'hFFFF_FFF0);
        wreg(3'd4, 32'h3000);
        wreg(3'd5, 32'h8000_0002);
        chk("R9", "armed by write", rld_armed, 1);
        chk("R9", "still active", chan_active, 1);
        rd();
        chk("R8", "src reload", src_addr, 32'h7FFF_FFF0);
        chk("R8", "dst reload", dst_addr, 32'h3000);
        chk("R8", "count reload", byte_count, 2);
        chk("R8", "stays active", chan_active, 1);
        chk("R8", "arm cleared", rld_armed, 0);
        chk("R8", "pulses", {ctz_pulse, rld_pulse}, 2'b11);
        chk("R3", "half on 2 left", rd_width, 1);
        rd();
        chk("R7", "after chain stop", chan_active, 0);
        chk("R7", "pulses", {ctz_pulse, rld_pulse}, 2'b10);
        chk("R5", "src after chain", src_addr, 32'h7FFF_FFF2);
        tick();
        chk("R8", "pulses gone", {ctz_pulse, rld_pulse}, 2'b00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule